// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block turns seven external interrupt pins into request flags for a small CPU core. Every pin passes through a two-flop synchroniser. It is then sampled only when the machine-cycle strobe is high, which happens once every twelve clocks. An edge counts only when two consecutive machine-cycle samples show the old level and then the new one. A qualifying edge or level sets the source's flag. Each flag is gated with its own enable bit, and the result drives a seven-bit request vector to the core.

Sources 2 and 3 have a type bit that selects rising or falling edges. Sources 4, 5 and 6 always trigger on a falling edge. Sources 0 and 1 are active-low, and their type bit selects between falling-edge mode and low-level mode. In low-level mode the flag simply follows the sampled pin. Edge-mode flags are cleared when the core signals that it has vectored to that source. Software reaches the flags, the type bits and the enables through a four-location byte register port. It can set or clear an edge flag directly, but a hardware set in the same cycle wins.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset every flag, type bit and enable bit is 0, `irq_req` is 0, and all four register locations read 0x00.
- R2: Pins act only through the synchronised sample taken in a cycle with `mc_stb` high. A pulse that begins and ends between two strobes sets no flag, and no edge flag becomes set in a cycle without a strobe or a write.
- R3: Location 0 holds the flags for sources 6..2 in bits 6..2, the type bit for source 3 in bit 1, and the type bit for source 2 in bit 0. For sources 2 and 3, type 1 sets the flag on a rising sample pair and type 0 on a falling sample pair.
- R4: Sources 4, 5 and 6 set their flags only on a falling sample pair. A rising pair leaves them unchanged.
- R5: Location 1 holds type0 in bit 0, flag0 in bit 1, type1 in bit 2 and flag1 in bit 3. With type 1, a falling sample pair sets the flag. With type 0, the flag equals the inverse of the sampled pin.
- R6: A cycle with `ack_vld` high clears only the edge-mode flag of the source selected by `ack_idx`. It has no effect on a source in level mode.
- R7: `irq_req[i]` is flag i AND enable i. Location 2 bits 1..0 hold the enables for sources 1..0, and location 3 bits 4..0 hold the enables for sources 6..2.
- R8: A write sets or clears edge flags to the written bit values. A hardware set in the same cycle takes precedence over a written 0.
- R9: Bit 7 of location 0 ignores writes and reads 0.
- R10: The first strobe after reset only captures a baseline sample and never counts as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_stb | input | 1 | Machine-cycle strobe, one clock in twelve |
| pin_i | input | 7 | External interrupt pins, bit i is source i |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register location |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| ack_vld | input | 1 | Vector acknowledge strobe |
| ack_idx | input | 3 | Source index being acknowledged |
| irq_req | output | 7 | Masked request vector |

## Verification
The hardest case to produce is a software write that clears a flag in the very clock where a hardware edge sets it. The bench gets there by changing a pin early enough for the change to pass the synchroniser. It then raises the strobe and the clearing write on the same clock and reads the flag back. Short pulses that fall entirely between strobes are driven with hand-counted clock delays. A reset is applied while a pin is held low, which shows that the first sample after reset is taken as a baseline and not as an edge.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int NSRC    = 7;
  localparam int SYNC_N  = 2;
  localparam int DW      = 8;
  localparam int AW      = 2;
  localparam int IDXW    = $clog2(NSRC);
  localparam int NTYPE   = 4;

  typedef enum logic [AW-1:0] {
    LOC_HI_FLAGS = 2'd0,
    LOC_LO_CTRL  = 2'd1,
    LOC_EN_LO    = 2'd2,
    LOC_EN_HI    = 2'd3
  } loc_e;
endpackage

// File: rtl/xirq_sampler.sv
module xirq_sampler #(
  parameter int N      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mc_stb,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] smp_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] sync_q [STAGES];
  logic [N-1:0] sync_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign sync_d[s] = pin_i;
    end else begin : g_next
      assign sync_d[s] = sync_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= '1;
      else        sync_q[s] <= sync_d[s];
    end
  end

  logic [N-1:0] cur;
  logic [N-1:0] smp_q, smp_d;
  logic         vld_q, vld_d;
  logic         qual;

  assign cur = sync_q[STAGES-1];

  always_comb begin
    smp_d = smp_q;
    vld_d = vld_q;
    if (mc_stb) begin
      smp_d = cur;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '1;
      vld_q <= 1'b0;
    end else begin
      smp_q <= smp_d;
      vld_q <= vld_d;
    end
  end

  assign qual   = mc_stb & vld_q;
  assign smp_o  = smp_q;
  assign rise_o = {N{qual}} & ~smp_q & cur;
  assign fall_o = {N{qual}} & smp_q & ~cur;
endmodule

// File: rtl/xirq_cfg.sv
module xirq_cfg
  import xirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [NTYPE-1:0] type_o,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] edge_mode_o,
  output logic [NSRC-1:0] rise_sel_o
);
  logic [NTYPE-1:0] type_q, type_d;
  logic [NSRC-1:0]  en_q, en_d;

  always_comb begin
    type_d = type_q;
    en_d   = en_q;
    if (wr_en) begin
      unique case (loc_e'(addr))
        LOC_HI_FLAGS: type_d[3:2] = wdata[1:0];
        LOC_LO_CTRL:  begin
          type_d[0] = wdata[0];
          type_d[1] = wdata[2];
        end
        LOC_EN_LO:    en_d[1:0] = wdata[1:0];
        LOC_EN_HI:    en_d[NSRC-1:2] = wdata[NSRC-3:0];
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      en_q   <= '0;
    end else begin
      type_q <= type_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    edge_mode_o    = '1;
    rise_sel_o     = '0;
    edge_mode_o[0] = type_q[0];
    edge_mode_o[1] = type_q[1];
    rise_sel_o[2]  = type_q[2];
    rise_sel_o[3]  = type_q[3];
  end

  assign type_o = type_q;
  assign en_o   = en_q;
endmodule

// File: rtl/xirq_flag_bank.sv
module xirq_flag_bank
  import xirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] smp,
  input  logic [NSRC-1:0] rise,
  input  logic [NSRC-1:0] fall,
  input  logic [NSRC-1:0] edge_mode,
  input  logic [NSRC-1:0] rise_sel,
  input  logic [NSRC-1:0] sw_wr,
  input  logic [NSRC-1:0] sw_val,
  input  logic            ack_vld,
  input  logic [IDXW-1:0] ack_idx,
  output logic [NSRC-1:0] eflag_o,
  output logic [NSRC-1:0] flag_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam logic [IDXW-1:0] MY_IDX = IDXW'(i);
    logic hw_set, ack_hit, ef_q, ef_d;

    assign hw_set  = rise_sel[i] ? rise[i] : fall[i];
    assign ack_hit = ack_vld && (ack_idx == MY_IDX);

    always_comb begin
      ef_d = ef_q;
      if (sw_wr[i])      ef_d = sw_val[i];
      if (ack_hit)       ef_d = 1'b0;
      if (hw_set)        ef_d = 1'b1;
      if (!edge_mode[i]) ef_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ef_q <= 1'b0;
      else        ef_q <= ef_d;
    end

    assign eflag_o[i] = ef_q;
    assign flag_o[i]  = edge_mode[i] ? ef_q : ~smp[i];
  end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mc_stb,
  input  logic [NSRC-1:0] pin_i,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  input  logic            ack_vld,
  input  logic [IDXW-1:0] ack_idx,
  output logic [NSRC-1:0] irq_req
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [NSRC-1:0]  smp, rise, fall;
  logic [NSRC-1:0]  en, edge_mode, rise_sel, eflag, flag;
  logic [NTYPE-1:0] typ;
  logic [NSRC-1:0]  sw_wr, sw_val;
  logic             unused_rsvd;

  assign unused_rsvd = wdata[7];

  xirq_sampler #(.N(NSRC), .STAGES(SYNC_N)) u_smp (
    .clk(clk), .rst_n(rst_n_i), .mc_stb(mc_stb), .pin_i(pin_i),
    .smp_o(smp), .rise_o(rise), .fall_o(fall)
  );

  xirq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n_i), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .type_o(typ), .en_o(en), .edge_mode_o(edge_mode), .rise_sel_o(rise_sel)
  );

  always_comb begin
    sw_wr  = '0;
    sw_val = '0;
    if (wr_en) begin
      unique case (loc_e'(addr))
        LOC_HI_FLAGS: begin
          sw_wr[NSRC-1:2]  = '1;
          sw_val[NSRC-1:2] = wdata[6:2];
        end
        LOC_LO_CTRL: begin
          sw_wr[1:0] = 2'b11;
          sw_val[0]  = wdata[1];
          sw_val[1]  = wdata[3];
        end
        default: ;
      endcase
    end
  end

  xirq_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n_i), .smp(smp), .rise(rise), .fall(fall),
    .edge_mode(edge_mode), .rise_sel(rise_sel), .sw_wr(sw_wr), .sw_val(sw_val),
    .ack_vld(ack_vld), .ack_idx(ack_idx), .eflag_o(eflag), .flag_o(flag)
  );

  always_comb begin
    rdata = '0;
    unique case (loc_e'(addr))
      LOC_HI_FLAGS: rdata = {1'b0, flag[6:2], typ[3], typ[2]};
      LOC_LO_CTRL:  rdata = {4'b0, flag[1], typ[1], flag[0], typ[0]};
      LOC_EN_LO:    rdata = {6'b0, en[1:0]};
      LOC_EN_HI:    rdata = {3'b0, en[6:2]};
      default:      rdata = '0;
    endcase
  end

  assign irq_req = flag & en;
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk
  import xirq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            mc_stb,
  input logic            wr_en,
  input logic            ack_vld,
  input logic [IDXW-1:0] ack_idx,
  input logic [NSRC-1:0] irq_req,
  input logic [NSRC-1:0] eflag,
  input logic [NSRC-1:0] en
);
  // R1: requests are quiet in the first cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> irq_req == '0);

  // R2: no edge flag becomes set without a strobe or a write
  a_r2_no_set_off_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_stb && !wr_en) |=> ((eflag & ~$past(eflag)) == '0));

  // R6: an acknowledge clears the addressed edge flag
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && !mc_stb && !wr_en && ack_idx < IDXW'(NSRC)) |=> !eflag[$past(ack_idx)]);

  // R7: a disabled source never requests
  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~en) == '0);
endmodule

bind xirq_ctrl xirq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mc_stb(mc_stb), .wr_en(wr_en),
  .ack_vld(ack_vld), .ack_idx(ack_idx), .irq_req(irq_req),
  .eflag(eflag), .en(en)
);

// File: tb/xirq_ctrl_bench.sv
module xirq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mc_stb;
  logic [6:0] pin_i;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       ack_vld;
  logic [2:0] ack_idx;
  logic [6:0] irq_req;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  xirq_ctrl u_xirq_ctrl (
    .clk(clk), .rst_n(rst_n), .mc_stb(mc_stb), .pin_i(pin_i),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ack_vld(ack_vld), .ack_idx(ack_idx), .irq_req(irq_req)
  );

  localparam logic [6:0] IDLE = 7'b1111011;

  // {pins, ack_vld, ack_idx, expected irq_req}
  localparam logic [17:0] VEC [16] = '{
    {7'b1111011, 1'b0, 3'd0, 7'b0000000}, // R4 idle
    {7'b1111010, 1'b0, 3'd0, 7'b0000001}, // R5 src0 falling edge
    {7'b1111010, 1'b1, 3'd0, 7'b0000000}, // R6 ack src0
    {7'b1111000, 1'b0, 3'd0, 7'b0000010}, // R5 src1 low level
    {7'b1111000, 1'b1, 3'd1, 7'b0000010}, // R6 ack ignored in level mode
    {7'b1111011, 1'b0, 3'd0, 7'b0000000}, // R5 level released, src0 rise ignored
    {7'b1111111, 1'b0, 3'd0, 7'b0000100}, // R3 src2 rising
    {7'b1111011, 1'b0, 3'd0, 7'b0000100}, // R3 src2 falling ignored in rise mode
    {7'b1111011, 1'b1, 3'd2, 7'b0000000}, // R6 ack src2
    {7'b1110011, 1'b0, 3'd0, 7'b0001000}, // R3 src3 falling
    {7'b0000011, 1'b0, 3'd0, 7'b1111000}, // R4 src4..6 falling
    {7'b0000011, 1'b1, 3'd5, 7'b1011000}, // R6 ack src5 only
    {7'b1111011, 1'b0, 3'd0, 7'b1011000}, // R4 rising leaves flags
    {7'b1111011, 1'b1, 3'd3, 7'b1010000}, // R6 ack src3
    {7'b1111011, 1'b1, 3'd4, 7'b1000000}, // R6 ack src4
    {7'b1111011, 1'b1, 3'd6, 7'b0000000}  // R6 ack src6
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic mcycle();
    repeat (11) @(negedge clk);
    mc_stb = 1'b1;
    @(negedge clk);
    mc_stb = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic ack(input logic [2:0] idx);
    ack_vld = 1'b1; ack_idx = idx;
    @(negedge clk);
    ack_vld = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 0x00 expected 0x01");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    mc_stb = 1'b0; pin_i = IDLE; wr_en = 1'b0; addr = '0; wdata = '0;
    ack_vld = 1'b0; ack_idx = '0;
    do_reset();

    // R1 reset state
    chk("R1 irq_req", {1'b0, irq_req}, 8'h00);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 register", d, 8'h00);
    end

    // configuration: src0 falling edge, src1 level, src2 rise, src3 fall
    wr(2'd2, 8'h03);
    wr(2'd3, 8'h1F);
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h01);
    mcycle();

    for (int i = 0; i < 16; i++) begin
      pin_i = VEC[i][17:11];
      mcycle();
      if (VEC[i][10]) ack(VEC[i][9:7]);
      #1;
      chk($sformatf("R3-6 vector %0d", i), {1'b0, irq_req}, {1'b0, VEC[i][6:0]});
    end

    // R8 software set and clear
    wr(2'd0, 8'h41);
    #1; chk("R8 sw set req", {1'b0, irq_req}, 8'h40);
    rd(2'd0, d); chk("R8 sw set read", d, 8'h41);
    wr(2'd0, 8'h01);
    #1; chk("R8 sw clear", {1'b0, irq_req}, 8'h00);

    // R9 reserved bit
    wr(2'd0, 8'h81);
    rd(2'd0, d); chk("R9 reserved bit", d, 8'h01);

    // R7 enable gating
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h21);
    #1; chk("R7 masked", {1'b0, irq_req}, 8'h00);
    rd(2'd0, d); chk("R7 flag kept", d, 8'h21);
    wr(2'd3, 8'h1F);
    #1; chk("R7 unmasked", {1'b0, irq_req}, 8'h20);
    wr(2'd0, 8'h01);

    // R3 src3 in rising mode
    wr(2'd0, 8'h03);
    pin_i = 7'b1110011; mcycle();
    #1; chk("R3 src3 fall ignored", {1'b0, irq_req}, 8'h00);
    pin_i = IDLE; mcycle();
    #1; chk("R3 src3 rise", {1'b0, irq_req}, 8'h08);
    wr(2'd0, 8'h01);

    // R8 hardware set beats a clearing write in the same cycle
    pin_i = 7'b0111011;
    repeat (11) @(negedge clk);
    mc_stb = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 8'h01;
    @(negedge clk);
    mc_stb = 1'b0; wr_en = 1'b0;
    rd(2'd0, d); chk("R8 hw wins", d, 8'h41);
    pin_i = IDLE; mcycle();
    wr(2'd0, 8'h01);

    // R2 pulse between strobes is missed
    pin_i = 7'b1101011;
    repeat (3) @(negedge clk);
    pin_i = IDLE;
    repeat (8) @(negedge clk);
    mc_stb = 1'b1; @(negedge clk); mc_stb = 1'b0;
    #1; chk("R2 short pulse", {1'b0, irq_req}, 8'h00);

    // R5 level flag readback on location 1
    pin_i = 7'b1111001; mcycle();
    rd(2'd1, d); chk("R5 level read", d, 8'h09);
    pin_i = IDLE; mcycle();
    rd(2'd1, d); chk("R5 level clear", d, 8'h01);

    // R10 first strobe after reset is a baseline
    pin_i = 7'b1110011;
    do_reset();
    chk("R1 irq after reset", {1'b0, irq_req}, 8'h00);
    mcycle();
    rd(2'd0, d); chk("R10 no edge at first strobe", d, 8'h00);
    mcycle();
    rd(2'd0, d); chk("R10 steady low", d, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule